// File: doc/BRIEF.md
# Idle-Compensating Transmit Elastic Buffer

This block moves byte-wide Ethernet transmit symbols (a data byte plus an enable bit and an error bit) from a write clock domain into a read clock domain. The two clocks run at nominally the same rate but can differ by a few parts per million. One symbol arrives on every write clock cycle and one symbol leaves on every read clock cycle. The buffer has no valid/ready handshake. It absorbs the rate mismatch by keeping its fill level close to half of its storage.

An idle symbol has both the enable bit and the error bit low. When the buffer runs too full, the write side deletes incoming idle symbols. When it runs too empty, the read side repeats the idle symbol at its head. Data and error symbols are never touched. The read and write pointers cross between the domains as Gray code. Each side computes its own, conservative view of the fill level.

After a reset, the read side sends idles until the buffer has filled to its midpoint. A write into a completely full buffer is lost and raises a sticky overflow flag in the write domain. A read from an empty buffer produces an idle and raises a sticky underflow flag in the read domain.

Top module: `tx_elastic_buf`

## Requirements
- R1: The buffer stores 64 entries, each holding data, enable and error. Every non-idle symbol accepted on the write side appears on the read side exactly once and in write order, with no drop and no repeat.
- R2: A symbol is idle exactly when enable = 0 and error = 0. The data byte plays no part in this. Enable = 0 with error = 1 is a non-idle symbol.
- R3: An incoming idle is discarded when the write side's fill view is 36 (depth/2 + 4) or more.
- R4: When the read side's fill view is 28 (depth/2 − 4) or less and the head entry is idle, that entry is output and the read pointer stays put, so the idle repeats.
- R5: After a read-side reset, the output is all zero (data 0, enable 0, error 0) until the read side's fill view reaches 32. Only then does reading start.
- R6: A write that finds the buffer holding 64 entries is discarded and sets the sticky output wr_overflow.
- R7: Once reading has started, a read-clock cycle that finds the buffer empty outputs an all-zero idle and sets the sticky output rd_underflow.
- R8: The outputs are registered. Each non-idle output appears on the same read-clock edge that advances the read pointer past it, and exactly one symbol is output per read-clock cycle.
- R9: Each domain has its own synchronous active-high reset. It clears that domain's pointer, synchronizer and flag, and the read reset forces an idle output. Pointers cross domains as Gray code through two flip-flops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write domain clock |
| wr_rst | input | 1 | Write domain synchronous reset, active high |
| in_data | input | 8 | Incoming data byte |
| in_en | input | 1 | Incoming enable bit |
| in_err | input | 1 | Incoming error bit |
| wr_overflow | output | 1 | Sticky: a write was lost because the buffer was full |
| rd_clk | input | 1 | Read domain clock |
| rd_rst | input | 1 | Read domain synchronous reset, active high |
| out_data | output | 8 | Outgoing data byte, registered |
| out_en | output | 1 | Outgoing enable bit, registered |
| out_err | output | 1 | Outgoing error bit, registered |
| rd_underflow | output | 1 | Sticky: a read found the buffer empty |

## Verification
A write is stored on the write edge that samples it. The read side sees it only after two synchronizer flops. The symbol then leaves through the output register, one read edge after the read decision. The exact arrival cycle therefore depends on clock phase. For this reason the bench compares the order and content of non-idle outputs against a queue on every falling read edge, not against a fixed cycle. The sticky flags and the all-zero output before priming are sampled at falling edges: after settle windows of many hundreds of cycles for the flags, and within the first 20 read cycles for the prime check. A fill of 32 cannot have crossed into the read domain by that point.

// File: rtl/teb_pkg.sv
package teb_pkg;
  typedef struct packed {
    logic [7:0] data;
    logic       en;
    logic       err;
  } teb_sym_t;

  function automatic logic sym_is_idle(teb_sym_t s);
    return !s.en && !s.err;
  endfunction
endpackage

// File: rtl/teb_ptr_sync.sv
module teb_ptr_sync #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] gray_in,
  output logic [W-1:0] bin_out
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= gray_in;
      sync_q <= meta_q;
    end
  end

  // Gray to binary: each bit is the XOR of itself and all higher bits
  always_comb begin
    for (int i = 0; i < W; i++) bin_out[i] = ^(sync_q >> i);
  end
endmodule

// File: rtl/teb_wr_side.sv
module teb_wr_side
  import teb_pkg::*;
#(
  parameter int ADDR_W = 6,
  localparam int PTR_W = ADDR_W + 1,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  teb_sym_t          sym_in,
  input  logic [PTR_W-1:0]  rptr_sync,
  output logic              we,
  output logic [ADDR_W-1:0] waddr,
  output logic [PTR_W-1:0]  wptr,
  output logic [PTR_W-1:0]  wptr_gray,
  output logic [PTR_W-1:0]  fill,
  output logic              overflow
);
  localparam logic [PTR_W-1:0] HI_MARK = PTR_W'(DEPTH / 2 + 4);
  localparam logic [PTR_W-1:0] FULL_LV = PTR_W'(DEPTH);

  logic             drop_idle, full;
  logic [PTR_W-1:0] wptr_nxt;

  always_comb begin
    fill      = wptr - rptr_sync;
    full      = fill >= FULL_LV;
    drop_idle = sym_is_idle(sym_in) && (fill >= HI_MARK);
    we        = !drop_idle && !full;
    waddr     = wptr[ADDR_W-1:0];
    wptr_nxt  = wptr + PTR_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr      <= '0;
      wptr_gray <= '0;
      overflow  <= 1'b0;
    end else begin
      if (we) begin
        wptr      <= wptr_nxt;
        wptr_gray <= wptr_nxt ^ (wptr_nxt >> 1);
      end
      if (!drop_idle && full) overflow <= 1'b1;
    end
  end
endmodule

// File: rtl/teb_rd_side.sv
module teb_rd_side
  import teb_pkg::*;
#(
  parameter int ADDR_W = 6,
  localparam int PTR_W = ADDR_W + 1,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PTR_W-1:0]  wptr_sync,
  input  teb_sym_t          head,
  output logic [ADDR_W-1:0] raddr,
  output logic [PTR_W-1:0]  rptr,
  output logic [PTR_W-1:0]  rptr_gray,
  output logic              primed,
  output teb_sym_t          sym_out,
  output logic              underflow
);
  localparam logic [PTR_W-1:0] LO_MARK  = PTR_W'(DEPTH / 2 - 4);
  localparam logic [PTR_W-1:0] MID_MARK = PTR_W'(DEPTH / 2);

  logic [PTR_W-1:0] fill, rptr_nxt;
  logic             empty, hold_idle, advance;

  always_comb begin
    fill      = wptr_sync - rptr;
    empty     = fill == '0;
    hold_idle = sym_is_idle(head) && (fill <= LO_MARK);
    advance   = primed && !empty && !hold_idle;
    raddr     = rptr[ADDR_W-1:0];
    rptr_nxt  = rptr + PTR_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rptr      <= '0;
      rptr_gray <= '0;
      primed    <= 1'b0;
      sym_out   <= '0;
      underflow <= 1'b0;
    end else begin
      if (!primed && fill >= MID_MARK) primed <= 1'b1;
      if (!primed || empty) sym_out <= '0;
      else                  sym_out <= head;
      if (primed && empty) underflow <= 1'b1;
      if (advance) begin
        rptr      <= rptr_nxt;
        rptr_gray <= rptr_nxt ^ (rptr_nxt >> 1);
      end
    end
  end
endmodule

// File: rtl/tx_elastic_buf.sv
module tx_elastic_buf
  import teb_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic       wr_clk,
  input  logic       wr_rst,
  input  logic [7:0] in_data,
  input  logic       in_en,
  input  logic       in_err,
  output logic       wr_overflow,
  input  logic       rd_clk,
  input  logic       rd_rst,
  output logic [7:0] out_data,
  output logic       out_en,
  output logic       out_err,
  output logic       rd_underflow
);
  localparam int PTR_W = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;

  teb_sym_t          mem [DEPTH];
  teb_sym_t          sym_in, head, sym_out;
  logic              we;
  logic [ADDR_W-1:0] waddr, raddr;
  logic [PTR_W-1:0]  wr_ptr, wr_gray, wr_fill, rptr_in_wr;
  logic [PTR_W-1:0]  rd_ptr, rd_gray, wptr_in_rd;
  logic              primed;

  assign sym_in = '{data: in_data, en: in_en, err: in_err};

  always_ff @(posedge wr_clk) begin
    if (we) mem[waddr] <= sym_in;
  end
  assign head = mem[raddr];

  teb_ptr_sync #(.W(PTR_W)) u_rsync (
    .clk(wr_clk), .rst(wr_rst), .gray_in(rd_gray), .bin_out(rptr_in_wr));
  teb_ptr_sync #(.W(PTR_W)) u_wsync (
    .clk(rd_clk), .rst(rd_rst), .gray_in(wr_gray), .bin_out(wptr_in_rd));

  teb_wr_side #(.ADDR_W(ADDR_W)) u_wr (
    .clk(wr_clk), .rst(wr_rst), .sym_in(sym_in), .rptr_sync(rptr_in_wr),
    .we(we), .waddr(waddr), .wptr(wr_ptr), .wptr_gray(wr_gray),
    .fill(wr_fill), .overflow(wr_overflow));

  teb_rd_side #(.ADDR_W(ADDR_W)) u_rd (
    .clk(rd_clk), .rst(rd_rst), .wptr_sync(wptr_in_rd), .head(head),
    .raddr(raddr), .rptr(rd_ptr), .rptr_gray(rd_gray), .primed(primed),
    .sym_out(sym_out), .underflow(rd_underflow));

  assign out_data = sym_out.data;
  assign out_en   = sym_out.en;
  assign out_err  = sym_out.err;
endmodule

// File: rtl/teb_checker.sv
module teb_checker #(
  parameter int PTR_W = 7,
  parameter int DEPTH = 64
) (
  input logic             wr_clk,
  input logic             wr_rst,
  input logic             in_en,
  input logic             in_err,
  input logic [PTR_W-1:0] wr_fill,
  input logic [PTR_W-1:0] wr_ptr,
  input logic             wr_overflow,
  input logic             rd_clk,
  input logic             rd_rst,
  input logic [PTR_W-1:0] rd_ptr,
  input logic             primed,
  input logic [7:0]       out_data,
  input logic             out_en,
  input logic             out_err,
  input logic             rd_underflow
);
  localparam logic [PTR_W-1:0] HI  = PTR_W'(DEPTH / 2 + 4);
  localparam logic [PTR_W-1:0] TOP = PTR_W'(DEPTH);

  p_idle_drop_r3: assert property (@(posedge wr_clk) disable iff (wr_rst)
    (!in_en && !in_err && wr_fill >= HI) |=> (wr_ptr == $past(wr_ptr)));

  p_nonidle_kept_r1: assert property (@(posedge wr_clk) disable iff (wr_rst)
    ((in_en || in_err) && wr_fill < TOP) |=> (wr_ptr == $past(wr_ptr) + PTR_W'(1)));

  p_ovf_sticky_r6: assert property (@(posedge wr_clk) disable iff (wr_rst)
    wr_overflow |=> wr_overflow);

  p_unf_sticky_r7: assert property (@(posedge rd_clk) disable iff (rd_rst)
    rd_underflow |=> rd_underflow);

  p_prime_idle_r5: assert property (@(posedge rd_clk) disable iff (rd_rst)
    !primed |=> (!out_en && !out_err && out_data == 8'h00));

  p_ptr_step_r8: assert property (@(posedge rd_clk) disable iff (rd_rst)
    (out_en || out_err) |-> (rd_ptr == $past(rd_ptr) + PTR_W'(1)));
endmodule

bind tx_elastic_buf teb_checker #(.PTR_W(ADDR_W + 1), .DEPTH(1 << ADDR_W)) u_teb_chk (
  .wr_clk(wr_clk), .wr_rst(wr_rst), .in_en(in_en), .in_err(in_err),
  .wr_fill(wr_fill), .wr_ptr(wr_ptr), .wr_overflow(wr_overflow),
  .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_ptr(rd_ptr), .primed(primed),
  .out_data(out_data), .out_en(out_en), .out_err(out_err),
  .rd_underflow(rd_underflow));

// File: tb/test_tx_elastic_buf.sv
`timescale 1ns/1ps
module test_tx_elastic_buf;
  logic       wr_clk = 1'b0, rd_clk = 1'b0;
  logic       wr_rst = 1'b1, rd_rst = 1'b1;
  logic [7:0] in_data = 8'h00;
  logic       in_en = 1'b0, in_err = 1'b0;
  logic [7:0] out_data;
  logic       out_en, out_err, wr_overflow, rd_underflow;

  real rd_half = 5.1;
  always #5 wr_clk = ~wr_clk;
  always #(rd_half) rd_clk = ~rd_clk;

  tx_elastic_buf i_tx_elastic_buf (
    .wr_clk(wr_clk), .wr_rst(wr_rst), .in_data(in_data), .in_en(in_en),
    .in_err(in_err), .wr_overflow(wr_overflow), .rd_clk(rd_clk), .rd_rst(rd_rst),
    .out_data(out_data), .out_en(out_en), .out_err(out_err),
    .rd_underflow(rd_underflow));

  int n_chk = 0, n_fail = 0, n_cmp = 0;
  bit model_on = 1'b0, cmp_on = 1'b0, done = 1'b0;
  logic [9:0] q[$];
  logic [7:0] cnt = 8'h00;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Reference model: queue of non-idle symbols in write order
  always @(posedge wr_clk)
    if (model_on && !wr_rst && (in_en || in_err)) q.push_back({in_data, in_en, in_err});

  always @(negedge rd_clk)
    if (cmp_on && !rd_rst && (out_en || out_err)) begin
      n_cmp++;
      if (q.size() == 0) check(1'b0, "R1/R8 unexpected non-idle", {out_data, out_en, out_err}, 0);
      else begin
        logic [9:0] e;
        e = q.pop_front();
        check({out_data, out_en, out_err} == e, "R1/R8 order", {out_data, out_en, out_err}, e);
      end
    end

  // Frames of 24 non-idle symbols and 12 idles; idles sometimes carry data (R2)
  task automatic drive(input int n, input bit all_data);
    for (int i = 0; i < n; i++) begin
      @(negedge wr_clk);
      if (all_data || (i % 36) < 24) begin
        cnt++;
        in_data = cnt;
        in_en   = (cnt % 13) != 0;
        in_err  = (cnt % 13) == 0 || (cnt % 17) == 5;
      end else begin
        in_data = (i % 3 == 0) ? 8'h07 : 8'h00;
        in_en   = 1'b0;
        in_err  = 1'b0;
      end
    end
  endtask

  initial begin
    repeat (5) @(negedge wr_clk);
    check(out_data == 0 && !out_en && !out_err, "R9 reset output", {out_data, out_en, out_err}, 0);
    check(!wr_overflow && !rd_underflow, "R9 reset flags", {wr_overflow, rd_underflow}, 0);
    model_on = 1'b1;
    cmp_on   = 1'b1;
    wr_rst   = 1'b0;
    @(negedge rd_clk);
    rd_rst = 1'b0;
    fork
      drive(6000, 1'b0);
      begin
        for (int k = 0; k < 20; k++) begin
          @(negedge rd_clk);
          check(out_data == 0 && !out_en && !out_err, "R5 idle before prime",
                {out_data, out_en, out_err}, 0);
        end
      end
    join
    check(n_cmp > 1000, "R5 reading started", n_cmp, 1000);
    check(!wr_overflow, "R3 slow reader no overflow", wr_overflow, 0);
    check(!rd_underflow, "R2 no underflow in slow phase", rd_underflow, 0);

    rd_half = 4.9;
    drive(6000, 1'b0);
    check(!rd_underflow, "R4 fast reader no underflow", rd_underflow, 0);
    check(!wr_overflow, "R2 no overflow in fast phase", wr_overflow, 0);

    rd_half = 4.0;
    drive(400, 1'b1);
    check(rd_underflow, "R7 underflow sticky", rd_underflow, 1);
    check(!wr_overflow, "R1 no overflow on drain", wr_overflow, 0);

    model_on = 1'b0;
    cmp_on   = 1'b0;
    rd_half  = 5.0;
    @(negedge rd_clk);
    rd_rst = 1'b1;
    drive(150, 1'b1);
    check(wr_overflow, "R6 overflow sticky", wr_overflow, 1);
    check(out_data == 0 && !out_en && !out_err, "R9 read reset idle",
          {out_data, out_en, out_err}, 0);
    check(!rd_underflow, "R9 read reset clears underflow", rd_underflow, 0);

    wr_rst = 1'b1;
    repeat (4) @(negedge wr_clk);
    check(!wr_overflow, "R9 write reset clears overflow", wr_overflow, 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1ms;
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule